// File: doc/BRIEF.md
# Flash Command Interface and Write Sequencer

This block sits between a byte-wide host bus and a small NOR-style flash array. The host writes command bytes and data using chip-enable, write-enable and output-enable strobes. The block decodes those writes into read-mode changes and status operations. It also decodes byte programming and block erasure, each of which runs for a parameterised number of clock cycles. A status register and a ready/busy pin report progress, suspension and errors. A small behavioural array model is included, so the whole path from command to stored byte can be exercised.

Programming and erasure can both be paused and continued. The two pauses can nest. While an erase is paused, the host may program a byte in a different block, and it may even pause that program in turn. A resume aimed at the paused erase is held back until the nested program has finished. Lock bits, a lock override, and a programming-voltage-good signal are plain digital inputs. They decide whether a program may start.

Top module: `flash_wsm_ctl`

## Requirements
- R1: A bus write is taken in the clock cycle where `we_ni` is first seen high after being low, provided `ce_ni` is low in that cycle. `addr_i` and `data_i` are captured in that same cycle.
- R2: With `ce_ni` and `oe_ni` both low, `data_o` shows either the array byte at `addr_i` or the status byte. Command FFh selects the array byte. Command 70h, either program setup (40h/10h), erase setup 20h, B0h or D0h, and the second write of a program or erase select the status byte. Clear-status (50h) leaves the read selection unchanged. With `ce_ni` or `oe_ni` high, `data_o` is 00h. After reset the array byte is selected and every array byte is FFh.
- R3: Byte program is setup 40h or 10h followed by a write of address and data. The cell becomes its old value AND the new data. The write lands after PRG_CYC run cycles, and `rdy_o` is low meanwhile.
- R4: The status bits are laid out as follows:
  - bit 7: ready (no operation is running);
  - bit 6: erase suspended;
  - bit 5: voltage/erase error;
  - bit 4: program error;
  - bit 2: program suspended;
  - bit 1: lock error;
  - bits 3 and 0: always read 0.

  `rdy_o` always equals bit 7.
- R5: Programming a 1 over a stored 0 does not set bit 4, and the cell stays 0.
- R6: A program accepted while `vpp_ok_i` is low sets bits 5 and 4. The array is not changed and `rdy_o` stays high.
- R7: A program accepted while the target block's `lock_i` bit is set and `ovr_i` is low sets bits 1 and 4, and the byte is not written. With `ovr_i` high the program proceeds.
- R8: Erase is 20h followed by D0h, with the block taken from the second write's address. After ERS_CYC run cycles every byte of that block reads FFh and other blocks are untouched. Any other second byte aborts the erase.
- R9: B0h during a running erase sets bits 7 and 6 and raises `rdy_o` SUSP_LAT cycles later. The erase does not progress while suspended.
- R10: While an erase is suspended, the following hold:
  - a program to a different block runs, with bit 7 at 0 and bit 6 at 1;
  - a program to the suspended block is ignored;
  - erase setup is ignored.
- R11: D0h written while an erase is suspended and a nested program is in progress takes effect only when that program completes.
- R12: B0h during a running program sets bits 7 and 2 SUSP_LAT cycles later. While a program is suspended, program setup and erase setup are ignored.
- R13: D0h clears the matching suspend bit and bit 7, and `rdy_o` goes low. The operation continues with its remaining cycles. A suspended program takes precedence over a suspended erase.
- R14: Clear-status (50h) resets bits 5, 4 and 1 and leaves bits 6 and 2 as they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; a write is taken on its rising edge |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Command or program data |
| data_o | output | 8 | Array byte or status byte |
| rdy_o | output | 1 | High when no operation is running |
| vpp_ok_i | input | 1 | Programming voltage good |
| lock_i | input | 2**(ADDR_W-BLK_W) | Lock bit per block |
| ovr_i | input | 1 | Lock override |

## Verification
The hardest state to reach is the double nesting. An erase must be paused, a program to another block must be launched inside that pause, and a resume must then arrive while that program is still counting. Only then can the deferral of the erase resume be observed. The stimulus starts a long erase and requests suspension. It waits for `rdy_o` to rise, then issues the two-cycle program and writes D0h a few cycles later, well inside PRG_CYC. A behavioural model in the bench tracks the remaining cycles of both operations. It flags any early resume as a mismatch on `rdy_o` or on the status byte.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam logic [7:0] CMD_RD_ARR = 8'hFF;
  localparam logic [7:0] CMD_RD_SR  = 8'h70;
  localparam logic [7:0] CMD_CLR_SR = 8'h50;
  localparam logic [7:0] CMD_PRG_A  = 8'h40;
  localparam logic [7:0] CMD_PRG_B  = 8'h10;
  localparam logic [7:0] CMD_ERS    = 8'h20;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_CONF   = 8'hD0;

  typedef enum logic [1:0] {SU_NONE, SU_PRG, SU_ERS} setup_e;
endpackage

// File: rtl/fwc_bus.sv
module fwc_bus (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  output logic wr_stb_o
);
  logic we_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;

  assign wr_stb_o = ~ce_ni & we_ni & ~we_q;
endmodule

// File: rtl/fwc_array.sv
module fwc_array #(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prg_en_i,
  input  logic [ADDR_W-1:0] prg_addr_i,
  input  logic [7:0]        prg_data_i,
  input  logic              ers_en_i,
  input  logic [ADDR_W-BLK_W-1:0] ers_blk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BA_W  = ADDR_W - BLK_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ers_en_i && ers_blk_i == BA_W'(i >> BLK_W))
          mem[i] <= 8'hFF;
        else if (prg_en_i && prg_addr_i == ADDR_W'(i))
          mem[i] <= mem[i] & prg_data_i;  // cells only move 1 -> 0
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/flash_wsm_ctl.sv
module flash_wsm_ctl
  import fwc_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BLK_W    = 4,
  parameter int PRG_CYC  = 8,
  parameter int ERS_CYC  = 40,
  parameter int SUSP_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              rdy_o,
  input  logic              vpp_ok_i,
  input  logic [(1 << (ADDR_W-BLK_W))-1:0] lock_i,
  input  logic              ovr_i
);
  localparam int BA_W  = ADDR_W - BLK_W;
  localparam int MAXC  = (ERS_CYC > PRG_CYC) ? ERS_CYC : PRG_CYC;
  localparam int CW    = $clog2(MAXC) + 1;
  localparam int LW    = $clog2(SUSP_LAT) + 1;

  logic              wr_stb;
  logic [BA_W-1:0]   wblk;
  logic              rd_sr;
  setup_e            setup;
  logic              prg_act, prg_susp, prg_sreq;
  logic [CW-1:0]     prg_cnt;
  logic [ADDR_W-1:0] prg_addr;
  logic [7:0]        prg_data;
  logic              ers_act, ers_susp, ers_sreq, ers_rres;
  logic [CW-1:0]     ers_cnt;
  logic [BA_W-1:0]   ers_blk;
  logic [LW-1:0]     lat_cnt;
  logic              e5, e4, e1;
  logic              prg_run, ers_run, prg_done, ers_done, busy;
  logic              lock_hit, prg_setup;
  logic [7:0]        sr, arr_q;

  fwc_bus u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .wr_stb_o(wr_stb)
  );

  assign wblk      = addr_i[ADDR_W-1:BLK_W];
  assign prg_run   = prg_act & ~prg_susp;
  assign ers_run   = ers_act & ~ers_susp;
  assign prg_done  = prg_run & (prg_cnt == '0);
  assign ers_done  = ers_run & (ers_cnt == '0);
  assign busy      = prg_run | ers_run;
  assign lock_hit  = lock_i[wblk] & ~ovr_i;
  assign prg_setup = (setup == SU_PRG);

  fwc_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .prg_en_i(prg_done), .prg_addr_i(prg_addr), .prg_data_i(prg_data),
    .ers_en_i(ers_done), .ers_blk_i(ers_blk),
    .rd_addr_i(addr_i), .rd_data_o(arr_q)
  );

  assign sr     = {~busy, ers_susp, e5, e4, 1'b0, prg_susp, e1, 1'b0};
  assign rdy_o  = ~busy;
  assign data_o = (~ce_ni & ~oe_ni) ? (rd_sr ? sr : arr_q) : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sr <= 1'b0; setup <= SU_NONE;
      prg_act <= 1'b0; prg_susp <= 1'b0; prg_sreq <= 1'b0; prg_cnt <= '0;
      prg_addr <= '0; prg_data <= '0;
      ers_act <= 1'b0; ers_susp <= 1'b0; ers_sreq <= 1'b0; ers_rres <= 1'b0;
      ers_cnt <= '0; ers_blk <= '0; lat_cnt <= '0;
      e5 <= 1'b0; e4 <= 1'b0; e1 <= 1'b0;
    end else begin
      // program progress
      if (prg_run) begin
        if (prg_cnt == '0) begin
          prg_act <= 1'b0; prg_sreq <= 1'b0;
          if (ers_rres) begin ers_susp <= 1'b0; ers_rres <= 1'b0; end
        end else begin
          prg_cnt <= prg_cnt - 1'b1;
          if (prg_sreq) begin
            if (lat_cnt == LW'(SUSP_LAT-1)) begin prg_susp <= 1'b1; prg_sreq <= 1'b0; end
            else lat_cnt <= lat_cnt + 1'b1;
          end
        end
      end
      // erase progress
      if (ers_run) begin
        if (ers_cnt == '0) begin
          ers_act <= 1'b0; ers_sreq <= 1'b0;
        end else begin
          ers_cnt <= ers_cnt - 1'b1;
          if (ers_sreq) begin
            if (lat_cnt == LW'(SUSP_LAT-1)) begin ers_susp <= 1'b1; ers_sreq <= 1'b0; end
            else lat_cnt <= lat_cnt + 1'b1;
          end
        end
      end
      // command decode
      if (wr_stb) begin
        setup <= SU_NONE;
        case (setup)
          SU_PRG: begin
            rd_sr <= 1'b1;
            if (!vpp_ok_i) begin e5 <= 1'b1; e4 <= 1'b1; end
            if (lock_hit)  begin e1 <= 1'b1; e4 <= 1'b1; end
            if (vpp_ok_i && !lock_hit && !(ers_act && wblk == ers_blk)) begin
              prg_act  <= 1'b1;
              prg_cnt  <= CW'(PRG_CYC-1);
              prg_addr <= addr_i;
              prg_data <= data_i;
            end
          end
          SU_ERS: begin
            rd_sr <= 1'b1;
            if (data_i == CMD_CONF && !ers_act && !prg_act) begin
              ers_act <= 1'b1;
              ers_cnt <= CW'(ERS_CYC-1);
              ers_blk <= wblk;
            end
          end
          default: begin
            case (data_i)
              CMD_RD_ARR: rd_sr <= 1'b0;
              CMD_RD_SR:  rd_sr <= 1'b1;
              CMD_CLR_SR: begin e5 <= 1'b0; e4 <= 1'b0; e1 <= 1'b0; end
              CMD_PRG_A, CMD_PRG_B: begin
                rd_sr <= 1'b1;
                if (!prg_act && !ers_run) setup <= SU_PRG;
              end
              CMD_ERS: begin
                rd_sr <= 1'b1;
                if (!prg_act && !ers_act) setup <= SU_ERS;
              end
              CMD_SUSP: begin
                rd_sr <= 1'b1;
                if (prg_run && !prg_sreq && prg_cnt != '0) begin
                  prg_sreq <= 1'b1; lat_cnt <= '0;
                end else if (ers_run && !ers_sreq && ers_cnt != '0) begin
                  ers_sreq <= 1'b1; lat_cnt <= '0;
                end
              end
              CMD_CONF: begin
                rd_sr <= 1'b1;
                if (prg_susp) prg_susp <= 1'b0;
                else if (ers_susp && !prg_act) ers_susp <= 1'b0;
                else if (ers_susp && prg_act) begin
                  // erase waits for the nested program
                  if (prg_done) ers_susp <= 1'b0;
                  else          ers_rres <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fwc_chk.sv
module fwc_chk #(
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_stb,
  input logic          prg_setup,
  input logic          lock_hit,
  input logic          vpp_ok_i,
  input logic          prg_act,
  input logic          prg_susp,
  input logic [CW-1:0] prg_cnt,
  input logic          ers_susp,
  input logic [CW-1:0] ers_cnt,
  input logic          rdy_o,
  input logic [7:0]    data_o,
  input logic          rd_sr,
  input logic          ce_ni,
  input logic          oe_ni
);
  p_rdy_mirror_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && rd_sr) |-> (data_o[7] == rdy_o));

  p_vpp_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && prg_setup && !vpp_ok_i) |=> (!prg_act && rdy_o));

  p_lock_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && prg_setup && lock_hit) |=> !prg_act);

  p_ers_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_susp |=> (ers_cnt == $past(ers_cnt)));

  p_defer_resume_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ers_susp && prg_act) |=> (ers_susp || !prg_act));

  p_prg_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_susp |=> (prg_cnt == $past(prg_cnt)));
endmodule

bind flash_wsm_ctl fwc_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb(wr_stb), .prg_setup(prg_setup),
  .lock_hit(lock_hit), .vpp_ok_i(vpp_ok_i), .prg_act(prg_act),
  .prg_susp(prg_susp), .prg_cnt(prg_cnt), .ers_susp(ers_susp),
  .ers_cnt(ers_cnt), .rdy_o(rdy_o), .data_o(data_o), .rd_sr(rd_sr),
  .ce_ni(ce_ni), .oe_ni(oe_ni)
);

// File: tb/flash_wsm_ctl_test.sv
module flash_wsm_ctl_test;
  localparam int AW = 6, BW = 4, PC = 8, EC = 40, SL = 3;
  localparam int NB = 1 << (AW - BW);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce = 1'b1, we = 1'b1, oe = 1'b1, vpp = 1'b1, ovr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [NB-1:0] lock = '0;
  logic [7:0] dout;
  logic rdy;

  always #2.5 clk = ~clk;

  flash_wsm_ctl #(.ADDR_W(AW), .BLK_W(BW), .PRG_CYC(PC), .ERS_CYC(EC), .SUSP_LAT(SL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce), .we_ni(we), .oe_ni(oe),
    .addr_i(addr), .data_i(din), .data_o(dout), .rdy_o(rdy),
    .vpp_ok_i(vpp), .lock_i(lock), .ovr_i(ovr)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input int act, input int exp, input string req);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  mm [64];
  bit  m_sr, m_weq;
  int  m_set;                  // 0 none, 1 program, 2 erase
  bit  pa, ps, pq, ea, es, eq, er;
  int  pc, padr, pdat, ec, eb, lc;
  bit  f5, f4, f1;

  function automatic bit m_busy();
    return (pa && !ps) || (ea && !es);
  endfunction

  function automatic int m_sr_val();
    return ({31'b0, !m_busy()} << 7) | (int'(es) << 6) | (int'(f5) << 5) |
           (int'(f4) << 4) | (int'(ps) << 2) | (int'(f1) << 1);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 64; i++) mm[i] = 8'hFF;
      m_sr = 0; m_weq = 1; m_set = 0;
      pa = 0; ps = 0; pq = 0; ea = 0; es = 0; eq = 0; er = 0;
      pc = 0; padr = 0; pdat = 0; ec = 0; eb = 0; lc = 0;
      f5 = 0; f4 = 0; f1 = 0;
    end else begin
      bit ws, o_pa, o_ps, o_pq, o_ea, o_es, o_eq, prun, erun, pdone;
      int o_pc, o_ec, o_set, blk, d;
      ws = !ce && we && !m_weq; m_weq = we;
      o_pa = pa; o_ps = ps; o_pq = pq; o_ea = ea; o_es = es; o_eq = eq;
      o_pc = pc; o_ec = ec; o_set = m_set;
      prun = pa && !ps; erun = ea && !es;
      pdone = prun && pc == 0;
      if (prun) begin
        if (pc == 0) begin
          mm[padr] = mm[padr] & pdat; pa = 0; pq = 0;
          if (er) begin es = 0; er = 0; end
        end else begin
          pc--;
          if (pq) begin if (lc == SL - 1) begin ps = 1; pq = 0; end else lc++; end
        end
      end
      if (erun) begin
        if (ec == 0) begin
          for (int i = 0; i < 64; i++) if ((i >> BW) == eb) mm[i] = 8'hFF;
          ea = 0; eq = 0;
        end else begin
          ec--;
          if (eq) begin if (lc == SL - 1) begin es = 1; eq = 0; end else lc++; end
        end
      end
      if (ws) begin
        blk = int'(addr) >> BW; d = int'(din);
        m_set = 0;
        if (o_set == 1) begin
          m_sr = 1;
          if (!vpp) begin f5 = 1; f4 = 1; end
          if (lock[blk] && !ovr) begin f1 = 1; f4 = 1; end
          if (vpp && !(lock[blk] && !ovr) && !(o_ea && blk == eb)) begin
            pa = 1; pc = PC - 1; padr = int'(addr); pdat = d;
          end
        end else if (o_set == 2) begin
          m_sr = 1;
          if (d == 8'hD0 && !o_ea && !o_pa) begin ea = 1; ec = EC - 1; eb = blk; end
        end else begin
          if (d == 8'hFF) m_sr = 0;
          else if (d == 8'h70) m_sr = 1;
          else if (d == 8'h50) begin f5 = 0; f4 = 0; f1 = 0; end
          else if (d == 8'h40 || d == 8'h10) begin
            m_sr = 1; if (!o_pa && !(o_ea && !o_es)) m_set = 1;
          end else if (d == 8'h20) begin
            m_sr = 1; if (!o_pa && !o_ea) m_set = 2;
          end else if (d == 8'hB0) begin
            m_sr = 1;
            if (o_pa && !o_ps && !o_pq && o_pc != 0) begin pq = 1; lc = 0; end
            else if (o_ea && !o_es && !o_eq && o_ec != 0) begin eq = 1; lc = 0; end
          end else if (d == 8'hD0) begin
            m_sr = 1;
            if (o_ps) ps = 0;
            else if (o_es && !o_pa) es = 0;
            else if (o_es && o_pa) begin if (pdone) es = 0; else er = 1; end
          end
        end
      end
    end
  end

  // compare every cycle (R2 read path, R4 ready pin)
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      int e;
      e = (!ce && !oe) ? (m_sr ? m_sr_val() : mm[int'(addr)]) : 0;
      chk(int'(dout), e, "R2 cycle data_o vs model");
      chk(int'(rdy), int'(!m_busy()), "R4 cycle rdy_o vs model");
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input int d);
    @(posedge clk); #1 ce = 0; we = 0; addr = AW'(a); din = 8'(d);
    @(posedge clk); #1 we = 1;
    @(posedge clk); #1 ce = 1;
  endtask

  task automatic rd(input int a, output int v);
    @(posedge clk); #1 ce = 0; oe = 0; addr = AW'(a);
    @(negedge clk); v = int'(dout);
    @(posedge clk); #1 ce = 1; oe = 1;
  endtask

  task automatic wait_rdy();
    int n = 0;
    @(negedge clk);
    while (!rdy && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R2 reset state: array mode, erased
    rd(5, v); chk(v, 8'hFF, "R2 reset array byte");
    chk(int'(rdy), 1, "R4 reset ready");
    wr(0, 8'h70); rd(0, v); chk(v, 8'h80, "R4 reset status");
    // R1 R3 program with 40h
    wr(5, 8'h40); wr(5, 8'hA5);
    rd(5, v); chk(v & 8'h80, 0, "R3 busy during program");
    wait_rdy(); rd(5, v); chk(v, 8'h80, "R3 status after program");
    wr(0, 8'hFF); rd(5, v); chk(v, 8'hA5, "R1 R3 programmed byte");
    // R5 alternate setup, AND semantics
    wr(5, 8'h10); wr(5, 8'h0F); wait_rdy();
    rd(5, v); chk(v, 8'h80, "R5 no error on 1 over 0");
    wr(0, 8'hFF); rd(5, v); chk(v, 8'h05, "R5 cell is AND");
    // R6 voltage low
    vpp = 0; wr(6, 8'h40); wr(6, 8'h00); vpp = 1;
    rd(6, v); chk(v, 8'hB0, "R6 status bits 5 4");
    wr(0, 8'hFF); rd(6, v); chk(v, 8'hFF, "R6 array unchanged");
    wr(0, 8'h50); wr(0, 8'h70); rd(0, v); chk(v, 8'h80, "R14 clear errors");
    // R7 lock
    lock = 4'b0010; wr(8'h12, 8'h40); wr(8'h12, 8'h00);
    rd(0, v); chk(v, 8'h92, "R7 status bits 1 4");
    wr(0, 8'hFF); rd(8'h12, v); chk(v, 8'hFF, "R7 locked byte unchanged");
    ovr = 1; wr(8'h12, 8'h40); wr(8'h12, 8'h3C); wait_rdy(); ovr = 0; lock = 0;
    wr(0, 8'hFF); rd(8'h12, v); chk(v, 8'h3C, "R7 override writes");
    wr(0, 8'h50);
    // R8 erase and abort
    wr(8'h21, 8'h40); wr(8'h21, 8'h00); wait_rdy();
    wr(8'h20, 8'h20); wr(8'h20, 8'hFF); chk(int'(rdy), 1, "R8 aborted erase idle");
    wr(8'h20, 8'h20); wr(8'h20, 8'hD0);
    rd(0, v); chk(v, 8'h00, "R8 busy during erase");
    wait_rdy(); wr(0, 8'hFF);
    rd(8'h21, v); chk(v, 8'hFF, "R8 block erased");
    rd(5, v); chk(v, 8'h05, "R8 other block kept");
    // R9 R10 R11 R14 nested suspend
    wr(8'h33, 8'h40); wr(8'h33, 8'h00); wait_rdy();
    wr(8'h30, 8'h20); wr(8'h30, 8'hD0); wr(0, 8'hB0); wait_rdy();
    rd(0, v); chk(v, 8'hC0, "R9 erase suspended bits 7 6");
    wr(8'h31, 8'h40); wr(8'h31, 8'h00);
    rd(0, v); chk(v, 8'hC0, "R10 same block program ignored");
    wr(0, 8'h20); rd(0, v); chk(v, 8'hC0, "R10 erase setup ignored");
    vpp = 0; wr(1, 8'h40); wr(1, 8'h00); vpp = 1;
    rd(0, v); chk(v, 8'hF0, "R6 error during suspend");
    wr(0, 8'h50); wr(0, 8'h70); rd(0, v); chk(v, 8'hC0, "R14 bit 6 kept");
    wr(1, 8'h40); wr(1, 8'h3C);
    rd(0, v); chk(v, 8'h40, "R10 program in erase suspend");
    wr(0, 8'hD0); rd(0, v); chk(v, 8'h40, "R11 resume deferred");
    wait_rdy(); rd(0, v); chk(v, 8'h80, "R11 erase completed");
    wr(0, 8'hFF);
    rd(1, v); chk(v, 8'h3C, "R10 nested program landed");
    rd(8'h33, v); chk(v, 8'hFF, "R13 erase finished block");
    // R12 R13 program suspend
    wr(2, 8'h40); wr(2, 8'h00); wr(0, 8'hB0); wait_rdy();
    rd(0, v); chk(v, 8'h84, "R12 program suspended bits 7 2");
    wr(0, 8'h20); rd(0, v); chk(v, 8'h84, "R12 erase setup ignored");
    wr(0, 8'h40); rd(0, v); chk(v, 8'h84, "R12 program setup ignored");
    wr(0, 8'hFF); rd(2, v); chk(v, 8'hFF, "R12 byte not yet written");
    wr(0, 8'hD0); rd(0, v); chk(v, 8'h00, "R13 resumed busy");
    wait_rdy(); wr(0, 8'hFF); rd(2, v); chk(v, 8'h00, "R13 program completed");
    oe = 1; @(negedge clk); chk(int'(dout), 0, "R2 output idle when disabled");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule